// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block models a single cell of a programmable logic device. Five product-term inputs arrive from an AND array outside the block. A mask picks which of them are OR-ed, together with a cascade input from the neighbouring cell, into a sum term. The sum goes through an XOR stage whose second operand is a product term, a fixed 0 or a fixed 1. The result feeds a storage element that works as a D, T, JK or SR flip-flop, or as a level-transparent latch. The cell drives an output pin value and a separate buried feedback value, and each one takes either the stored bit or the combinational XOR result. The cell also passes its sum term on as a cascade output and gives an inverted copy of one product term as a foldback term.

A 44-bit configuration word sets every choice. The word is captured only while `cfg_load` is high. All behaviour runs on one emulation clock `clk`. The three global cell clocks and the product-term clock are level inputs sampled on that clock. A rising cell-clock edge is seen as low on one tick and high on the next. The clear and preset sources act on the next tick, whatever the cell clock or enable is doing.

The storage element is a two-state machine with states `ST_CLR` and `ST_SET`. Its transitions are:
- **clear**: to `ST_CLR` when reset is active.
- **preset**: to `ST_SET` when preset is active and reset is not.
- **capture**: to the state given by the mode rule on an enabled edge, or while the latch is open.
- **hold**: stay in the same state in every other case.

Top module: `plc_macrocell`

## Requirements
- R1: After `rst_n` is low, the configuration word reads all zero and the stored bit is 0. With all inputs at 0, `out_o`, `fb_o` and `casc_out` are 0 and `fold_n` is 1.
- R2: The sum term is the OR of `casc_in` and every `pt[i]` whose mask bit (configuration bits 43:39, bit i for term i) is 1. A term whose mask bit is 0 has no effect. `casc_out` equals the sum term.
- R3: The combinational value is the sum XOR an operand. The operand is chosen by a code in bits 38:37: 0 gives constant 0, 1 gives constant 1, 2 gives `pt` at the index in bits 36:34.
- R4: Register data is chosen by a code in bits 33:32: 0 gives the XOR result, 1 gives `pt` at the index in bits 31:29, 2 gives `pin_in`.
- R5: Mode code 0 in bits 28:26 is D mode: the stored bit takes the data on a rising edge of the cell clock and holds at all other times.
- R6: Mode 1 (T) inverts the stored bit on an edge when data is 1. Mode 2 (JK) uses data as J and `pt` at the index in bits 7:5 as K, and follows the JK table, where J=K=1 toggles.
- R7: Mode 3 (SR) uses data as S and the same K term as R. S alone sets, R alone clears, and S=R=1 or S=R=0 holds.
- R8: Mode 4 (latch) copies data on every tick while the cell clock is high and holds while it is low.
- R9: The clock code in bits 25:24 picks `gclk[0]`, `gclk[1]` or `gclk[2]` (codes 0 to 2), or `pt` at the index in bits 23:21 (code 3). Edges on the clocks that are not selected have no effect.
- R10: With bit 20 set and a global clock selected, `pt` at the index in bits 19:17 is a clock enable, and edges are ignored while it is 0. With the product-term clock selected, the enable is ignored.
- R11: The reset code in bits 16:15 is 0 for none, 1 for `gclr`, 2 for `pt` at the index in bits 14:12, and 3 for the OR of those two. Bit 11 enables preset from `pt` at the index in bits 10:8. Active reset clears the stored bit on the next tick, overriding the preset and any clock edge.
- R12: Bit 4 set makes `out_o` the stored bit, and clear makes it the combinational value. Bit 3 makes the same choice for `fb_o`, independently of bit 4.
- R13: `fold_n` is the inverse of `pt` at the index in bits 2:0.
- R14: `cfg_in` is captured only on a tick with `cfg_load` high. At all other times it is ignored and the captured word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low system reset |
| cfg_load | input | 1 | Strobe that captures the configuration word |
| cfg_in | input | 44 | Configuration word |
| pt | input | 5 | Product-term inputs |
| casc_in | input | 1 | Cascade sum from the neighbouring cell |
| pin_in | input | 1 | Direct pin value for register data |
| gclk | input | 3 | Global cell clocks (levels) |
| gclr | input | 1 | Global clear level |
| out_o | output | 1 | Output pin value |
| fb_o | output | 1 | Buried feedback value |
| casc_out | output | 1 | Sum term passed to the next cell |
| fold_n | output | 1 | Inverted foldback product term |

## Verification
Three things can act on the storage element in the same tick: a reset, a preset and a capture edge. The bench causes this by raising `gclr` while the preset term is high, and by pulsing the selected global clock with data at 1 while the clear is held. The register must read 0 in both cases. A further check releases the reset while the preset stays high, and the register must then read 1. This confirms that reset wins only while it is active and does not leave the state stuck.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int MC_NPT   = 5;
    localparam int MC_IW    = 3;
    localparam int MC_NGCLK = 3;

    typedef enum logic [1:0] {XS_ZERO = 2'd0, XS_ONE = 2'd1, XS_PT = 2'd2} mc_xsel_e;
    typedef enum logic [1:0] {D_XOR = 2'd0, D_PT = 2'd1, D_PIN = 2'd2} mc_dsrc_e;
    typedef enum logic [2:0] {M_D = 3'd0, M_T = 3'd1, M_JK = 3'd2, M_SR = 3'd3, M_LATCH = 3'd4} mc_mode_e;
    typedef enum logic [1:0] {CK_G0 = 2'd0, CK_G1 = 2'd1, CK_G2 = 2'd2, CK_PT = 2'd3} mc_ck_e;
    typedef enum logic [1:0] {AR_OFF = 2'd0, AR_GCLR = 2'd1, AR_PT = 2'd2, AR_BOTH = 2'd3} mc_ar_e;
    typedef enum logic {ST_CLR = 1'b0, ST_SET = 1'b1} mc_st_e;

    typedef struct packed {
        logic [MC_NPT-1:0] or_mask;
        mc_xsel_e          xsel;
        logic [MC_IW-1:0]  xor_idx;
        mc_dsrc_e          dsrc;
        logic [MC_IW-1:0]  d_idx;
        mc_mode_e          mode;
        mc_ck_e            ck;
        logic [MC_IW-1:0]  ck_idx;
        logic              ce_on;
        logic [MC_IW-1:0]  ce_idx;
        mc_ar_e            ar;
        logic [MC_IW-1:0]  ar_idx;
        logic              ap_on;
        logic [MC_IW-1:0]  ap_idx;
        logic [MC_IW-1:0]  k_idx;
        logic              out_reg;
        logic              fb_reg;
        logic [MC_IW-1:0]  fold_idx;
    } mc_cfg_t;

    localparam int MC_CFG_W = $bits(mc_cfg_t);

    function automatic logic mc_pick(input logic [MC_NPT-1:0] v, input logic [MC_IW-1:0] idx);
        logic r;
        r = 1'b0;
        for (int k = 0; k < MC_NPT; k++) begin
            if (idx == MC_IW'(k)) r = v[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/mc_sum_xor.sv
module mc_sum_xor
    import mc_pkg::*;
(
    input  logic [MC_NPT-1:0] pt_i,
    input  logic              casc_i,
    input  logic [MC_NPT-1:0] or_mask_i,
    input  mc_xsel_e          xsel_i,
    input  logic [MC_IW-1:0]  xor_idx_i,
    input  logic [MC_IW-1:0]  fold_idx_i,
    output logic              sum_o,
    output logic              xor_o,
    output logic              fold_n_o
);
    logic [MC_NPT-1:0] gated;
    logic              operand;

    for (genvar g = 0; g < MC_NPT; g++) begin : g_gate
        assign gated[g] = pt_i[g] & or_mask_i[g];
    end

    assign sum_o = (|gated) | casc_i;

    always_comb begin
        unique case (xsel_i)
            XS_ZERO: operand = 1'b0;
            XS_ONE:  operand = 1'b1;
            XS_PT:   operand = mc_pick(pt_i, xor_idx_i);
            default: operand = 1'b0;
        endcase
    end

    assign xor_o    = sum_o ^ operand;
    assign fold_n_o = ~mc_pick(pt_i, fold_idx_i);

    always_comb begin
        if (or_mask_i == '0) assert_mask_off_R2: assert (sum_o == casc_i);
    end
endmodule

// File: rtl/mc_ctrl_sel.sv
module mc_ctrl_sel
    import mc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MC_NGCLK-1:0] gclk_i,
    input  logic [MC_NPT-1:0]   pt_i,
    input  logic                gclr_i,
    input  mc_ck_e              ck_i,
    input  logic [MC_IW-1:0]    ck_idx_i,
    input  logic                ce_on_i,
    input  logic [MC_IW-1:0]    ce_idx_i,
    input  mc_ar_e              ar_i,
    input  logic [MC_IW-1:0]    ar_idx_i,
    input  logic                ap_on_i,
    input  logic [MC_IW-1:0]    ap_idx_i,
    output logic                edge_o,
    output logic                level_o,
    output logic                ar_act_o,
    output logic                ap_act_o
);
    logic [MC_NGCLK-1:0] hit;
    logic [1:0]          ck_code;
    logic                sel_lvl;
    logic                prev_q;
    logic                ce_ok;
    logic                ar_pt;

    assign ck_code = ck_i;

    for (genvar g = 0; g < MC_NGCLK; g++) begin : g_gclk
        assign hit[g] = gclk_i[g] & (ck_code == 2'(g));
    end

    assign sel_lvl = (ck_i == CK_PT) ? mc_pick(pt_i, ck_idx_i) : (|hit);
    assign ce_ok   = (ce_on_i && ck_i != CK_PT) ? mc_pick(pt_i, ce_idx_i) : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_lvl;
    end

    assign edge_o  = sel_lvl & ~prev_q & ce_ok;
    assign level_o = sel_lvl & ce_ok;

    assign ar_pt = mc_pick(pt_i, ar_idx_i);
    always_comb begin
        unique case (ar_i)
            AR_OFF:  ar_act_o = 1'b0;
            AR_GCLR: ar_act_o = gclr_i;
            AR_PT:   ar_act_o = ar_pt;
            AR_BOTH: ar_act_o = gclr_i | ar_pt;
            default: ar_act_o = 1'b0;
        endcase
    end
    assign ap_act_o = ap_on_i & mc_pick(pt_i, ap_idx_i);

    assert_ce_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_on_i && ck_i != CK_PT && !mc_pick(pt_i, ce_idx_i)) |-> !edge_o);
    assert_edge_needs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> prev_q);
endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mc_mode_e mode_i,
    input  logic     d_i,
    input  logic     k_i,
    input  logic     edge_i,
    input  logic     level_i,
    input  logic     ar_i,
    input  logic     ap_i,
    output logic     q_o
);
    mc_st_e st_q, st_nx;

    function automatic mc_st_e to_st(input logic b);
        return b ? ST_SET : ST_CLR;
    endfunction

    always_comb begin
        st_nx = st_q;
        if (ar_i) begin
            st_nx = ST_CLR;
        end else if (ap_i) begin
            st_nx = ST_SET;
        end else if (mode_i == M_LATCH) begin
            if (level_i) st_nx = to_st(d_i);
        end else if (edge_i) begin
            unique case (mode_i)
                M_D:  st_nx = to_st(d_i);
                M_T:  if (d_i) st_nx = (st_q == ST_SET) ? ST_CLR : ST_SET;
                M_JK: begin
                    if (d_i && k_i)  st_nx = (st_q == ST_SET) ? ST_CLR : ST_SET;
                    else if (d_i)    st_nx = ST_SET;
                    else if (k_i)    st_nx = ST_CLR;
                end
                M_SR: begin
                    if (d_i && !k_i)      st_nx = ST_SET;
                    else if (k_i && !d_i) st_nx = ST_CLR;
                end
                default: st_nx = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_CLR;
        else        st_q <= st_nx;
    end

    always_comb begin
        q_o = (st_q == ST_SET);
    end

    assert_reset_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ar_i |=> !q_o);
    assert_preset_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_i && !ar_i) |=> q_o);
    assert_hold_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar_i && !ap_i && mode_i != M_LATCH && !edge_i) |=> $stable(q_o));
    assert_sr_both_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_SR && edge_i && d_i && k_i && !ar_i && !ap_i) |=> $stable(q_o));
    assert_jk_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_JK && edge_i && d_i && k_i && !ar_i && !ap_i) |=> (q_o != $past(q_o)));
    assert_latch_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_LATCH && !level_i && !ar_i && !ap_i) |=> $stable(q_o));
endmodule

// File: rtl/plc_macrocell.sv
module plc_macrocell
    import mc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic [MC_CFG_W-1:0] cfg_in,
    input  logic [MC_NPT-1:0]   pt,
    input  logic                casc_in,
    input  logic                pin_in,
    input  logic [MC_NGCLK-1:0] gclk,
    input  logic                gclr,
    output logic                out_o,
    output logic                fb_o,
    output logic                casc_out,
    output logic                fold_n
);
    mc_cfg_t cfg_q;
    logic    sum, xr, data, kterm, q;
    logic    cell_edge, cell_level, ar_act, ap_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_q <= '0;
        else if (cfg_load) cfg_q <= mc_cfg_t'(cfg_in);
    end

    mc_sum_xor u_sum (
        .pt_i       (pt),
        .casc_i     (casc_in),
        .or_mask_i  (cfg_q.or_mask),
        .xsel_i     (cfg_q.xsel),
        .xor_idx_i  (cfg_q.xor_idx),
        .fold_idx_i (cfg_q.fold_idx),
        .sum_o      (sum),
        .xor_o      (xr),
        .fold_n_o   (fold_n)
    );

    mc_ctrl_sel u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .gclk_i   (gclk),
        .pt_i     (pt),
        .gclr_i   (gclr),
        .ck_i     (cfg_q.ck),
        .ck_idx_i (cfg_q.ck_idx),
        .ce_on_i  (cfg_q.ce_on),
        .ce_idx_i (cfg_q.ce_idx),
        .ar_i     (cfg_q.ar),
        .ar_idx_i (cfg_q.ar_idx),
        .ap_on_i  (cfg_q.ap_on),
        .ap_idx_i (cfg_q.ap_idx),
        .edge_o   (cell_edge),
        .level_o  (cell_level),
        .ar_act_o (ar_act),
        .ap_act_o (ap_act)
    );

    always_comb begin
        unique case (cfg_q.dsrc)
            D_XOR:   data = xr;
            D_PT:    data = mc_pick(pt, cfg_q.d_idx);
            D_PIN:   data = pin_in;
            default: data = 1'b0;
        endcase
    end

    assign kterm = mc_pick(pt, cfg_q.k_idx);

    mc_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (cfg_q.mode),
        .d_i     (data),
        .k_i     (kterm),
        .edge_i  (cell_edge),
        .level_i (cell_level),
        .ar_i    (ar_act),
        .ap_i    (ap_act),
        .q_o     (q)
    );

    assign casc_out = sum;
    assign out_o    = cfg_q.out_reg ? q : xr;
    assign fb_o     = cfg_q.fb_reg  ? q : xr;

    assert_cfg_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(cfg_q));
    assert_cfg_take_R14: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (cfg_q == mc_cfg_t'($past(cfg_in))));
endmodule

// File: tb/plc_macrocell_bench.sv
module plc_macrocell_bench;
    import mc_pkg::*;

    localparam int CLK_P = 10;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                cfg_load;
    logic [MC_CFG_W-1:0] cfg_in;
    logic [MC_NPT-1:0]   pt;
    logic                casc_in, pin_in, gclr;
    logic [MC_NGCLK-1:0] gclk;
    logic                out_o, fb_o, casc_out, fold_n;

    int tests = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    plc_macrocell u_plc_macrocell (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_in(cfg_in),
        .pt(pt), .casc_in(casc_in), .pin_in(pin_in), .gclk(gclk), .gclr(gclr),
        .out_o(out_o), .fb_o(fb_o), .casc_out(casc_out), .fold_n(fold_n)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_load = 1'b0; cfg_in = '0; pt = '0;
        casc_in = 1'b0; pin_in = 1'b0; gclr = 1'b0; gclk = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic load(input mc_cfg_t c);
        cfg_in = c; cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
    endtask

    task automatic pulse(input int i);
        gclk[i] = 1'b1; tick();
        gclk[i] = 1'b0; tick();
    endtask

    function automatic mc_cfg_t reg_pin(input mc_mode_e m);
        mc_cfg_t c;
        c = '0; c.mode = m; c.dsrc = D_PIN; c.out_reg = 1'b1; c.ck = CK_G0;
        return c;
    endfunction

    task automatic t_reset();
        do_reset();
        chk("R1 out", out_o, 1'b0);
        chk("R1 fb", fb_o, 1'b0);
        chk("R1 casc", casc_out, 1'b0);
        chk("R1 fold", fold_n, 1'b1);
    endtask

    task automatic t_sum();
        mc_cfg_t c;
        do_reset();
        c = '0; c.or_mask = 5'b00101; load(c);
        pt = 5'b00010; tick();
        chk("R2 unmasked term", casc_out, 1'b0);
        chk("R2 unmasked out", out_o, 1'b0);
        pt = 5'b00100; tick();
        chk("R2 masked term", casc_out, 1'b1);
        pt = 5'b00000; casc_in = 1'b1; tick();
        chk("R2 cascade in", casc_out, 1'b1);
        chk("R2 cascade out", out_o, 1'b1);
    endtask

    task automatic t_xor();
        mc_cfg_t c;
        do_reset();
        c = '0; c.or_mask = 5'b00001; c.xsel = XS_ONE; load(c);
        chk("R3 invert of 0", out_o, 1'b1);
        pt = 5'b00001; tick();
        chk("R3 invert of 1", out_o, 1'b0);
        c.xsel = XS_PT; c.xor_idx = 3'd3; load(c);
        pt = 5'b01001; tick();
        chk("R3 pt operand 1^1", out_o, 1'b0);
        pt = 5'b00001; tick();
        chk("R3 pt operand 1^0", out_o, 1'b1);
    endtask

    task automatic t_fold();
        mc_cfg_t c;
        do_reset();
        c = '0; c.fold_idx = 3'd2; load(c);
        pt = 5'b00100; tick();
        chk("R13 fold high term", fold_n, 1'b0);
        pt = 5'b11011; tick();
        chk("R13 fold low term", fold_n, 1'b1);
    endtask

    task automatic t_dmode();
        mc_cfg_t c;
        do_reset();
        c = '0; c.or_mask = 5'b00001; c.mode = M_D; c.ck = CK_G0; c.out_reg = 1'b1;
        load(c);
        pt = 5'b00001; tick();
        chk("R5 no edge hold", out_o, 1'b0);
        chk("R12 fb comb", fb_o, 1'b1);
        pulse(0);
        chk("R5 capture xor", out_o, 1'b1);
        pt = 5'b00000; tick();
        chk("R5 hold after data drop", out_o, 1'b1);
        chk("R12 fb comb follows", fb_o, 1'b0);
        pulse(0);
        chk("R5 capture 0", out_o, 1'b0);
        c.dsrc = D_PIN; load(c);
        pin_in = 1'b1; pulse(0);
        chk("R4 pin source", out_o, 1'b1);
        pin_in = 1'b0;
        c.dsrc = D_PT; c.d_idx = 3'd4; load(c);
        pulse(0);
        chk("R4 pt source 0", out_o, 1'b0);
        pt = 5'b10000; pulse(0);
        chk("R4 pt source 1", out_o, 1'b1);
    endtask

    task automatic t_fbreg();
        mc_cfg_t c;
        do_reset();
        c = '0; c.or_mask = 5'b00001; c.mode = M_D; c.ck = CK_G0; c.fb_reg = 1'b1;
        load(c);
        pt = 5'b00001; tick();
        chk("R12 out comb", out_o, 1'b1);
        chk("R12 fb reg before edge", fb_o, 1'b0);
        pulse(0);
        chk("R12 fb reg after edge", fb_o, 1'b1);
        pt = 5'b00000; tick();
        chk("R12 out comb drop", out_o, 1'b0);
        chk("R12 fb reg held", fb_o, 1'b1);
    endtask

    task automatic t_clksel();
        mc_cfg_t c;
        do_reset();
        c = reg_pin(M_D); c.ck = CK_G2; load(c);
        pin_in = 1'b1;
        pulse(0); pulse(1);
        chk("R9 other clocks ignored", out_o, 1'b0);
        pulse(2);
        chk("R9 gclk2 captures", out_o, 1'b1);
        do_reset();
        c = reg_pin(M_D); c.ck = CK_PT; c.ck_idx = 3'd1; load(c);
        pin_in = 1'b1; pt = 5'b00010; tick();
        chk("R9 pt clock rise", out_o, 1'b1);
        pin_in = 1'b0; pt = 5'b00000; tick();
        chk("R9 pt clock fall no capture", out_o, 1'b1);
    endtask

    task automatic t_ce();
        mc_cfg_t c;
        do_reset();
        c = reg_pin(M_D); c.ce_on = 1'b1; c.ce_idx = 3'd3; load(c);
        pin_in = 1'b1; pulse(0);
        chk("R10 enable low blocks", out_o, 1'b0);
        pt = 5'b01000; pulse(0);
        chk("R10 enable high passes", out_o, 1'b1);
        do_reset();
        c = reg_pin(M_D); c.ck = CK_PT; c.ck_idx = 3'd1; c.ce_on = 1'b1; c.ce_idx = 3'd3;
        load(c);
        pin_in = 1'b1; pt = 5'b00010; tick();
        chk("R10 enable ignored on pt clock", out_o, 1'b1);
    endtask

    task automatic t_tjk();
        mc_cfg_t c;
        do_reset();
        c = reg_pin(M_T); load(c);
        pin_in = 1'b1; pulse(0);
        chk("R6 T toggle up", out_o, 1'b1);
        pulse(0);
        chk("R6 T toggle down", out_o, 1'b0);
        pin_in = 1'b0; pulse(0);
        chk("R6 T hold", out_o, 1'b0);
        do_reset();
        c = reg_pin(M_JK); c.k_idx = 3'd2; load(c);
        pin_in = 1'b1; pt = 5'b00000; pulse(0);
        chk("R6 JK set", out_o, 1'b1);
        pt = 5'b00100; pulse(0);
        chk("R6 JK toggle 1->0", out_o, 1'b0);
        pulse(0);
        chk("R6 JK toggle 0->1", out_o, 1'b1);
        pin_in = 1'b0; pulse(0);
        chk("R6 JK reset", out_o, 1'b0);
        pt = 5'b00000; pulse(0);
        chk("R6 JK hold", out_o, 1'b0);
    endtask

    task automatic t_sr();
        mc_cfg_t c;
        do_reset();
        c = reg_pin(M_SR); c.k_idx = 3'd2; load(c);
        pin_in = 1'b1; pulse(0);
        chk("R7 set", out_o, 1'b1);
        pt = 5'b00100; pulse(0);
        chk("R7 both hold high", out_o, 1'b1);
        pin_in = 1'b0; pulse(0);
        chk("R7 reset", out_o, 1'b0);
        pin_in = 1'b1; pulse(0);
        chk("R7 both hold low", out_o, 1'b0);
    endtask

    task automatic t_latch();
        mc_cfg_t c;
        do_reset();
        c = reg_pin(M_LATCH); load(c);
        pin_in = 1'b1; gclk[0] = 1'b1; tick();
        chk("R8 open passes 1", out_o, 1'b1);
        pin_in = 1'b0; tick();
        chk("R8 open passes 0", out_o, 1'b0);
        gclk[0] = 1'b0; pin_in = 1'b1; tick();
        chk("R8 closed holds", out_o, 1'b0);
        tick();
        chk("R8 closed still holds", out_o, 1'b0);
    endtask

    task automatic t_async();
        mc_cfg_t c;
        do_reset();
        c = reg_pin(M_D); c.ar = AR_GCLR; load(c);
        pin_in = 1'b1; pulse(0);
        chk("R11 setup capture", out_o, 1'b1);
        gclr = 1'b1; tick();
        chk("R11 gclr clears", out_o, 1'b0);
        pulse(0);
        chk("R11 clear beats edge", out_o, 1'b0);
        gclr = 1'b0; pulse(0);
        chk("R11 capture after clear", out_o, 1'b1);
        c.ar = AR_OFF; load(c);
        gclr = 1'b1; tick();
        chk("R11 clear disabled", out_o, 1'b1);
        gclr = 1'b0;
        c.ar = AR_PT; c.ar_idx = 3'd3; load(c);
        pt = 5'b01000; tick();
        chk("R11 pt clear", out_o, 1'b0);
        pt = 5'b00000;
        c.ar = AR_BOTH; c.ap_on = 1'b1; c.ap_idx = 3'd4; load(c);
        pt = 5'b10000; tick();
        chk("R11 preset", out_o, 1'b1);
        gclr = 1'b1; tick();
        chk("R11 reset wins over preset", out_o, 1'b0);
        gclr = 1'b0; tick();
        chk("R11 preset after reset release", out_o, 1'b1);
        pt = 5'b00000; tick();
        chk("R11 holds after preset release", out_o, 1'b1);
        pt = 5'b01000; tick();
        chk("R11 OR source pt clears", out_o, 1'b0);
    endtask

    task automatic t_cfg();
        mc_cfg_t c;
        do_reset();
        c = '0; c.xsel = XS_ONE; load(c);
        chk("R14 loaded", out_o, 1'b1);
        cfg_in = '0; tick(); tick();
        chk("R14 ignored without strobe", out_o, 1'b1);
        cfg_load = 1'b1; tick(); cfg_load = 1'b0;
        chk("R14 taken with strobe", out_o, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_sum();
        t_xor();
        t_fold();
        t_dmode();
        t_fbreg();
        t_clksel();
        t_ce();
        t_tjk();
        t_sr();
        t_latch();
        t_async();
        t_cfg();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule